// File: doc/BRIEF.md
# Trilinear MIPmap Texture Sampler

The sampler turns one texture lookup request into one filtered RGBA colour. A request carries unsigned fixed-point coordinates u and v, given in texel units of the full-resolution level, and a fixed-point level-of-detail value. The integer part of the level-of-detail value selects the finer of two adjacent pyramid levels. Its fraction weights the finer level against the next coarser one. A per-request filter mode picks one of four filters: a single texel, a 2x2 footprint in one level, one texel from each of two levels, or a 2x2 footprint in each of two levels.

The block drives a single-read texel memory port with a fixed return latency. It issues one read per cycle in a fixed step order. It expands each returned word from one of three storage formats to four 8-bit channels. It then accumulates weight times channel for each of red, green, blue and alpha on its own, and presents a rounded colour with a one-cycle valid strobe. Results leave in the order the requests were accepted. When every request is a single-texel lookup, the block accepts one request every cycle.

Top module: `tms_sampler`

## Requirements
- R1: Filter mode 0 (point) reads the single texel (floor(u>>L)>>4, floor(v>>L)>>4) at level L = integer part of the level-of-detail value. The output equals that texel's expanded colour exactly.
- R2: Filter mode 1 (bilinear) reads the texels (x0,y0), (x0+1,y0), (x0,y0+1), (x0+1,y0+1) at level L. fu and fv are the 4 fraction bits of u>>L and v>>L. The weights are (16-fu)(16-fv), fu(16-fv), (16-fu)fv and fu*fv. Each channel is (sum of weight*channel + 128) >> 8.
- R3: Filter mode 2 (level pair) reads texel (x0,y0) at level L and texel (x0,y0) at level L+1, each with its own scaled coordinates. fl is the 4-bit fraction of the level-of-detail value. The weights are 16-fl and fl. Each channel is (sum + 8) >> 4.
- R4: Filter mode 3 (trilinear) reads the R2 footprint at level L and at level L+1. Each texel's weight is its bilinear weight times the level weight of R3. Each channel is (sum + 2048) >> 12.
- R5: When the integer part of the level-of-detail value is at or above the coarsest level MAX_LVL, both levels become MAX_LVL and the fraction has no effect. No read addresses a level beyond MAX_LVL.
- R6: The +1 neighbour index on each axis is clamped to the last texel of the level, (2^(BASE_LOG2-L))-1. No read lies outside the level.
- R7: A request issues exactly 1, 4, 2 or 8 reads for modes 0, 1, 2 and 3. Reads go out on consecutive cycles.
- R8: Texel format 0 takes red, green, blue and alpha from bits [31:24], [23:16], [15:8] and [7:0]. Format 1 takes 5-6-5 red, green and blue from bits [15:11], [10:5] and [4:0], widens each field by repeating its top bits, and sets alpha to 255. Formats 2 and 3 copy intensity bits [7:0] into red, green and blue and set alpha to 255.
- R9: In mode 0 the block accepts a new request every cycle. For a request of N reads, req_ready stays low for the N-1 cycles after acceptance.
- R10: Results appear in acceptance order. out_valid rises MEM_LAT+N clock edges after the accepting edge, where N is the request's read count.
- R11: During reset and right after it, out_valid and mem_rd are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_u | input | BASE_LOG2+FRAC_W | Horizontal coordinate, level-0 texel units, FRAC_W fraction bits |
| req_v | input | BASE_LOG2+FRAC_W | Vertical coordinate, same format |
| req_lod | input | LOD_IW+FRAC_W | Level of detail, integer and fraction |
| req_mode | input | 2 | Filter mode 0..3 (R1 to R4) |
| req_fmt | input | 2 | Texel storage format (R8) |
| mem_rd | output | 1 | Texel read strobe |
| mem_lvl | output | LVL_W | Pyramid level of the read |
| mem_x | output | BASE_LOG2 | Column within the level |
| mem_y | output | BASE_LOG2 | Row within the level |
| mem_rdata | input | 32 | Texel word, valid MEM_LAT cycles after its read |
| out_valid | output | 1 | Filtered colour valid for one cycle |
| out_color | output | 32 | Red [31:24], green [23:16], blue [15:8], alpha [7:0] |

## Verification
The hardest cases to reach are the clamped ones. They need a level-of-detail value with the fraction ignored at the coarsest level, and footprints whose +1 neighbour falls off the last row or column of a small level. Only a few coordinate and level-of-detail pairs land there. The stimulus therefore sweeps u and v in odd steps across the whole 8x8 base level, always including the last texel. It crosses these with integer level values both below and above the coarsest level, in all four modes. The bench computes each expected colour from the weight formulas. The texel contents are a deterministic function of level, row and column, which exposes any wrong address or weight.

// File: rtl/tms_pkg.sv
package tms_pkg;
   localparam int CH_W    = 8;
   localparam int NCH     = 4;
   localparam int TEXEL_W = CH_W * NCH;

   typedef enum logic [1:0] {
      FILT_POINT = 2'd0,
      FILT_BILIN = 2'd1,
      FILT_LPAIR = 2'd2,
      FILT_TRI   = 2'd3
   } filt_e;

   typedef enum logic [1:0] {
      FMT_RGBA32 = 2'd0,
      FMT_RGB565 = 2'd1,
      FMT_INT8   = 2'd2,
      FMT_INT8B  = 2'd3
   } fmt_e;

   // index of the final read step for each filter
   function automatic logic [2:0] final_step(filt_e m);
      case (m)
         FILT_POINT: return 3'd0;
         FILT_BILIN: return 3'd3;
         FILT_LPAIR: return 3'd1;
         default:    return 3'd7;
      endcase
   endfunction
endpackage

// File: rtl/tms_coord_scale.sv
// Scales one fixed-point coordinate to a pyramid level and yields the
// base index, the clamped neighbour index and the fraction.
module tms_coord_scale #(
   parameter  int BASE_LOG2 = 4,
   parameter  int FRAC_W    = 4,
   parameter  int LVL_W     = 3,
   localparam int CW        = BASE_LOG2 + FRAC_W
) (
   input  logic [CW-1:0]        coord,
   input  logic [LVL_W-1:0]     lvl,
   output logic [BASE_LOG2-1:0] idx0,
   output logic [BASE_LOG2-1:0] idx1,
   output logic [FRAC_W-1:0]    frac
);
   logic [CW-1:0]      scaled;
   logic [BASE_LOG2:0] last_idx;

   always_comb begin
      scaled   = coord >> lvl;
      frac     = scaled[FRAC_W-1:0];
      idx0     = scaled[FRAC_W +: BASE_LOG2];
      last_idx = ((BASE_LOG2+1)'(1) << (BASE_LOG2 - int'(lvl))) - (BASE_LOG2+1)'(1);
      idx1     = ({1'b0, idx0} == last_idx) ? idx0 : idx0 + 1'b1;
   end
endmodule

// File: rtl/tms_issue.sv
// Holds the accepted request and steps through its texel reads,
// one per cycle, producing address and blend weight for each.
module tms_issue
   import tms_pkg::*;
#(
   parameter  int BASE_LOG2 = 4,
   parameter  int FRAC_W    = 4,
   parameter  int LOD_IW    = 3,
   parameter  int MAX_LVL   = 4,
   parameter  int LVL_W     = 3,
   localparam int CW        = BASE_LOG2 + FRAC_W,
   localparam int LODW      = LOD_IW + FRAC_W,
   localparam int WW        = 3 * FRAC_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [CW-1:0]        req_u,
   input  logic [CW-1:0]        req_v,
   input  logic [LODW-1:0]      req_lod,
   input  logic [1:0]           req_mode,
   input  logic [1:0]           req_fmt,
   output logic                 mem_rd,
   output logic [LVL_W-1:0]     mem_lvl,
   output logic [BASE_LOG2-1:0] mem_x,
   output logic [BASE_LOG2-1:0] mem_y,
   output logic                 tag_first,
   output logic                 tag_last,
   output logic [WW-1:0]        tag_w,
   output logic [1:0]           tag_fmt
);
   localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;

   logic               busy_q;
   logic [CW-1:0]      crd_q [2];
   logic [LVL_W-1:0]   l0_q, l1_q;
   logic [FRAC_W-1:0]  fl_q;
   filt_e              mode_q;
   logic [1:0]         fmt_q;
   logic [2:0]         step_q;

   // level decode of the incoming request
   logic [LOD_IW-1:0]  lod_int;
   logic [FRAC_W-1:0]  lod_frac;
   logic               lod_clamp;
   logic [LVL_W-1:0]   l0_d, l1_d;
   logic [FRAC_W-1:0]  fl_d;

   always_comb begin
      lod_int   = req_lod[FRAC_W +: LOD_IW];
      lod_frac  = req_lod[FRAC_W-1:0];
      lod_clamp = int'(lod_int) >= MAX_LVL;
      l0_d      = lod_clamp ? LVL_W'(MAX_LVL) : LVL_W'(lod_int);
      l1_d      = lod_clamp ? LVL_W'(MAX_LVL) : LVL_W'(lod_int) + 1'b1;
      fl_d      = lod_clamp ? '0 : lod_frac;
   end

   // step decode
   logic [2:0] last_idx;
   logic       use_xy, use_lv, xsel, ysel, lsel;
   logic [LVL_W-1:0] cur_lvl;

   always_comb begin
      last_idx = final_step(mode_q);
      use_xy   = (mode_q == FILT_BILIN) || (mode_q == FILT_TRI);
      use_lv   = (mode_q == FILT_LPAIR) || (mode_q == FILT_TRI);
      xsel     = use_xy & step_q[0];
      ysel     = use_xy & step_q[1];
      case (mode_q)
         FILT_TRI:   lsel = step_q[2];
         FILT_LPAIR: lsel = step_q[0];
         default:    lsel = 1'b0;
      endcase
      cur_lvl  = lsel ? l1_q : l0_q;
   end

   // per-axis scaling: axis 0 is u, axis 1 is v
   logic [BASE_LOG2-1:0] ax_i0 [2];
   logic [BASE_LOG2-1:0] ax_i1 [2];
   logic [FRAC_W-1:0]    ax_f  [2];
   logic                 ax_sel [2];
   logic [FRAC_W:0]      ax_w  [2];

   assign ax_sel[0] = xsel;
   assign ax_sel[1] = ysel;

   for (genvar a = 0; a < 2; a++) begin : g_axis
      tms_coord_scale #(
         .BASE_LOG2 (BASE_LOG2),
         .FRAC_W    (FRAC_W),
         .LVL_W     (LVL_W)
      ) u_scale (
         .coord (crd_q[a]),
         .lvl   (cur_lvl),
         .idx0  (ax_i0[a]),
         .idx1  (ax_i1[a]),
         .frac  (ax_f[a])
      );
      always_comb begin
         if (!use_xy)
            ax_w[a] = ONE;
         else if (ax_sel[a])
            ax_w[a] = {1'b0, ax_f[a]};
         else
            ax_w[a] = ONE - {1'b0, ax_f[a]};
      end
   end

   logic [FRAC_W:0] lv_w;

   always_comb begin
      if (!use_lv)
         lv_w = ONE;
      else if (lsel)
         lv_w = {1'b0, fl_q};
      else
         lv_w = ONE - {1'b0, fl_q};
      tag_w     = WW'(ax_w[0]) * WW'(ax_w[1]) * WW'(lv_w);
      mem_rd    = busy_q;
      mem_lvl   = cur_lvl;
      mem_x     = xsel ? ax_i1[0] : ax_i0[0];
      mem_y     = ysel ? ax_i1[1] : ax_i0[1];
      tag_first = (step_q == 3'd0);
      tag_last  = (step_q == last_idx);
      tag_fmt   = fmt_q;
      req_ready = !busy_q || (step_q == last_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         step_q   <= '0;
         crd_q[0] <= '0;
         crd_q[1] <= '0;
         l0_q     <= '0;
         l1_q     <= '0;
         fl_q     <= '0;
         mode_q   <= FILT_POINT;
         fmt_q    <= '0;
      end else if (req_ready) begin
         busy_q <= req_valid;
         step_q <= '0;
         if (req_valid) begin
            crd_q[0] <= req_u;
            crd_q[1] <= req_v;
            l0_q     <= l0_d;
            l1_q     <= l1_d;
            fl_q     <= fl_d;
            mode_q   <= filt_e'(req_mode);
            fmt_q    <= req_fmt;
         end
      end else begin
         step_q <= step_q + 3'd1;
      end
   end
endmodule

// File: rtl/tms_unpack.sv
// Expands a stored texel word into four 8-bit channels.
module tms_unpack
   import tms_pkg::*;
(
   input  logic [TEXEL_W-1:0] texel,
   input  logic [1:0]         fmt,
   output logic [TEXEL_W-1:0] color
);
   logic [4:0] r5, b5;
   logic [5:0] g6;
   logic [7:0] lum;

   always_comb begin
      r5  = texel[15:11];
      g6  = texel[10:5];
      b5  = texel[4:0];
      lum = texel[7:0];
      case (fmt_e'(fmt))
         FMT_RGBA32: color = texel;
         FMT_RGB565: color = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2], 8'hFF};
         default:    color = {lum, lum, lum, 8'hFF};
      endcase
   end
endmodule

// File: rtl/tms_blend.sv
// Weighted accumulation of a run of texels, one channel per lane.
module tms_blend
   import tms_pkg::*;
#(
   parameter  int FRAC_W = 4,
   localparam int WW     = 3 * FRAC_W + 1,
   localparam int SH     = 3 * FRAC_W,
   localparam int ACC_W  = CH_W + SH + 2,
   localparam int HALF   = 1 << (SH - 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_first,
   input  logic               in_last,
   input  logic [WW-1:0]      in_w,
   input  logic [TEXEL_W-1:0] in_color,
   output logic               out_valid,
   output logic [TEXEL_W-1:0] out_color
);
   for (genvar c = 0; c < NCH; c++) begin : g_lane
      logic [ACC_W-1:0] acc_q, acc_d;
      logic [CH_W-1:0]  res_q, res_d;

      always_comb begin
         acc_d = (in_first ? '0 : acc_q)
               + ACC_W'(in_w) * ACC_W'(in_color[c*CH_W +: CH_W]);
         res_d = CH_W'((acc_d + ACC_W'(HALF)) >> SH);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
         end else if (in_valid) begin
            acc_q <= acc_d;
            if (in_last) res_q <= res_d;
         end
      end

      assign out_color[c*CH_W +: CH_W] = res_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid & in_last;
   end
endmodule

// File: rtl/tms_sampler.sv
// Top level: read sequencer, fixed-latency tag pipe, format expansion
// and per-channel blend.
module tms_sampler
   import tms_pkg::*;
#(
   parameter  int BASE_LOG2 = 4,
   parameter  int FRAC_W    = 4,
   parameter  int LOD_IW    = 3,
   parameter  int MAX_LVL   = BASE_LOG2,
   parameter  int MEM_LAT   = 2,
   localparam int CW        = BASE_LOG2 + FRAC_W,
   localparam int LODW      = LOD_IW + FRAC_W,
   localparam int LVL_W     = $clog2(MAX_LVL + 1),
   localparam int WW        = 3 * FRAC_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [CW-1:0]        req_u,
   input  logic [CW-1:0]        req_v,
   input  logic [LODW-1:0]      req_lod,
   input  logic [1:0]           req_mode,
   input  logic [1:0]           req_fmt,
   output logic                 mem_rd,
   output logic [LVL_W-1:0]     mem_lvl,
   output logic [BASE_LOG2-1:0] mem_x,
   output logic [BASE_LOG2-1:0] mem_y,
   input  logic [31:0]          mem_rdata,
   output logic                 out_valid,
   output logic [31:0]          out_color
);
   // elaboration-time parameter checks
   if (BASE_LOG2 < 1 || BASE_LOG2 > 12) begin : g_bad_base
      $error("tms_sampler: BASE_LOG2 must lie in 1..12");
   end
   if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_frac
      $error("tms_sampler: FRAC_W must lie in 1..8");
   end
   if (MAX_LVL < 1 || MAX_LVL > BASE_LOG2) begin : g_bad_lvl
      $error("tms_sampler: MAX_LVL must lie in 1..BASE_LOG2");
   end
   if ((1 << LOD_IW) <= MAX_LVL) begin : g_bad_lod
      $error("tms_sampler: LOD_IW too narrow to reach MAX_LVL");
   end
   if (MEM_LAT < 1) begin : g_bad_lat
      $error("tms_sampler: MEM_LAT must be at least 1");
   end

   localparam int TAG_W = 3 + 2 + WW;

   logic          iss_first, iss_last;
   logic [WW-1:0] iss_w;
   logic [1:0]    iss_fmt;

   tms_issue #(
      .BASE_LOG2 (BASE_LOG2),
      .FRAC_W    (FRAC_W),
      .LOD_IW    (LOD_IW),
      .MAX_LVL   (MAX_LVL),
      .LVL_W     (LVL_W)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_u     (req_u),
      .req_v     (req_v),
      .req_lod   (req_lod),
      .req_mode  (req_mode),
      .req_fmt   (req_fmt),
      .mem_rd    (mem_rd),
      .mem_lvl   (mem_lvl),
      .mem_x     (mem_x),
      .mem_y     (mem_y),
      .tag_first (iss_first),
      .tag_last  (iss_last),
      .tag_w     (iss_w),
      .tag_fmt   (iss_fmt)
   );

   // tag pipe: one stage per cycle of memory latency
   logic [TAG_W-1:0] tag_pipe [MEM_LAT];

   for (genvar s = 0; s < MEM_LAT; s++) begin : g_tag
      always_ff @(posedge clk) begin
         if (!rst_n)
            tag_pipe[s] <= '0;
         else if (s == 0)
            tag_pipe[s] <= {mem_rd, iss_first, iss_last, iss_fmt, iss_w};
         else
            tag_pipe[s] <= tag_pipe[(s == 0) ? 0 : s-1];
      end
   end

   logic          al_valid, al_first, al_last;
   logic [1:0]    al_fmt;
   logic [WW-1:0] al_w;
   logic [31:0]   texel_rgba;

   assign {al_valid, al_first, al_last, al_fmt, al_w} = tag_pipe[MEM_LAT-1];

   tms_unpack u_unpack (
      .texel (mem_rdata),
      .fmt   (al_fmt),
      .color (texel_rgba)
   );

   tms_blend #(
      .FRAC_W (FRAC_W)
   ) u_blend (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (al_valid),
      .in_first  (al_first),
      .in_last   (al_last),
      .in_w      (al_w),
      .in_color  (texel_rgba),
      .out_valid (out_valid),
      .out_color (out_color)
   );
endmodule

// File: rtl/tms_sampler_chk.sv
module tms_sampler_chk #(
   parameter int BASE_LOG2 = 4,
   parameter int MAX_LVL   = 4,
   parameter int LVL_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [1:0]           req_mode,
   input logic                 mem_rd,
   input logic [LVL_W-1:0]     mem_lvl,
   input logic [BASE_LOG2-1:0] mem_x,
   input logic [BASE_LOG2-1:0] mem_y,
   input logic                 out_valid
);
   logic               acc;
   logic [3:0]         rd_cnt_q, exp_q, exp_d;
   logic               seen_q;
   logic [15:0]        pend_q;
   logic [BASE_LOG2:0] lvl_edge;

   always_comb begin
      acc = req_valid && req_ready;
      case (req_mode)
         2'd0:    exp_d = 4'd1;
         2'd1:    exp_d = 4'd4;
         2'd2:    exp_d = 4'd2;
         default: exp_d = 4'd8;
      endcase
      lvl_edge = ((BASE_LOG2+1)'(1) << (BASE_LOG2 - int'(mem_lvl))) - (BASE_LOG2+1)'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt_q <= '0;
         exp_q    <= '0;
         seen_q   <= 1'b0;
         pend_q   <= '0;
      end else begin
         if (acc) begin
            rd_cnt_q <= '0;
            exp_q    <= exp_d;
            seen_q   <= 1'b1;
         end else if (mem_rd) begin
            rd_cnt_q <= rd_cnt_q + 4'd1;
         end
         pend_q <= pend_q + 16'(acc) - 16'(out_valid);
      end
   end

   // R7: the finished request issued exactly its read count
   assert_read_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && seen_q) |-> ((rd_cnt_q + 4'(mem_rd)) == exp_q));

   // R9: a point request frees the port for the next one a cycle later
   assert_point_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_mode == 2'd0) |=> (mem_rd && req_ready));

   // R6: every read lies inside its level
   assert_addr_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (({1'b0, mem_x} <= lvl_edge) && ({1'b0, mem_y} <= lvl_edge)));

   // R5: no read beyond the coarsest level
   assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (int'(mem_lvl) <= MAX_LVL));

   // R10: a result never appears without an outstanding request
   assert_no_orphan_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pend_q != 16'd0));
endmodule

bind tms_sampler tms_sampler_chk #(
   .BASE_LOG2 (BASE_LOG2),
   .MAX_LVL   (MAX_LVL),
   .LVL_W     (LVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_mode  (req_mode),
   .mem_rd    (mem_rd),
   .mem_lvl   (mem_lvl),
   .mem_x     (mem_x),
   .mem_y     (mem_y),
   .out_valid (out_valid)
);

// File: tb/tb_tms_sampler.sv
`timescale 1ns/1ps
module tb_tms_sampler;
   localparam int BL   = 3;
   localparam int F    = 4;
   localparam int LIW  = 3;
   localparam int MAXL = 3;
   localparam int LAT  = 2;
   localparam int CW   = BL + F;
   localparam int LODW = LIW + F;
   localparam int LVW  = $clog2(MAXL + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [CW-1:0]   req_u = '0, req_v = '0;
   logic [LODW-1:0] req_lod = '0;
   logic [1:0]      req_mode = '0, req_fmt = '0;
   logic            mem_rd;
   logic [LVW-1:0]  mem_lvl;
   logic [BL-1:0]   mem_x, mem_y;
   logic [31:0]     mem_rdata;
   logic            out_valid;
   logic [31:0]     out_color;

   always #2.5 clk = ~clk;

   tms_sampler #(
      .BASE_LOG2 (BL), .FRAC_W (F), .LOD_IW (LIW), .MAX_LVL (MAXL), .MEM_LAT (LAT)
   ) dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
      .req_u (req_u), .req_v (req_v), .req_lod (req_lod), .req_mode (req_mode),
      .req_fmt (req_fmt), .mem_rd (mem_rd), .mem_lvl (mem_lvl), .mem_x (mem_x),
      .mem_y (mem_y), .mem_rdata (mem_rdata), .out_valid (out_valid),
      .out_color (out_color)
   );

   function automatic logic [31:0] tex_word(int l, int x, int y);
      return {8'(x*29 + y*7 + l*61), 8'(y*53 + x*3 + l*11),
              8'(x*x*5 + y*13 + l), 8'(x*y*9 + l*45 + 17)};
   endfunction

   // texel memory with fixed latency LAT
   logic [31:0] mpipe [LAT];
   always @(posedge clk) begin
      mpipe[0] <= mem_rd ? tex_word(int'(mem_lvl), int'(mem_x), int'(mem_y)) : 32'h0;
      for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
   end
   assign mem_rdata = mpipe[LAT-1];

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_fail = 0, stalls = 0;
   bit done = 0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R8 channel expansion, red at index 0
   function automatic int chan(logic [31:0] w, int fmt, int ch);
      int r5, g6, b5, i8;
      r5 = int'(w[15:11]); g6 = int'(w[10:5]); b5 = int'(w[4:0]); i8 = int'(w[7:0]);
      if (fmt == 0) return int'(w[31-8*ch -: 8]);
      if (fmt == 1) begin
         case (ch)
            0: return (r5 << 3) | (r5 >> 2);
            1: return (g6 << 2) | (g6 >> 4);
            2: return (b5 << 3) | (b5 >> 2);
            default: return 255;
         endcase
      end
      return (ch == 3) ? 255 : i8;
   endfunction

   function automatic int nreads(int mode);
      case (mode) 0: return 1; 1: return 4; 2: return 2; default: return 8; endcase
   endfunction

   // R1..R6 arithmetic model
   function automatic logic [31:0] expect_px(int u, int v, int lod, int mode, int fmt);
      int li, lf, lv, su, sv, x0, y0, fu, fv, sz, x, y, w, sh, sum;
      logic [31:0] res;
      int lvls [2];
      li = lod >> F; lf = lod & 15;
      if (li >= MAXL) begin lvls[0] = MAXL; lvls[1] = MAXL; lf = 0; end
      else begin lvls[0] = li; lvls[1] = li + 1; end
      sh = (mode == 0) ? 0 : (mode == 1) ? 8 : (mode == 2) ? 4 : 12;
      res = '0;
      for (int ch = 0; ch < 4; ch++) begin
         sum = 0;
         for (int ls = 0; ls < 2; ls++)
            for (int ys = 0; ys < 2; ys++)
               for (int xs = 0; xs < 2; xs++) begin
                  lv = lvls[ls];
                  su = u >> lv; sv = v >> lv;
                  x0 = su >> F; y0 = sv >> F; fu = su & 15; fv = sv & 15;
                  sz = 1 << (BL - lv);
                  x = xs ? ((x0 + 1 > sz - 1) ? sz - 1 : x0 + 1) : x0;
                  y = ys ? ((y0 + 1 > sz - 1) ? sz - 1 : y0 + 1) : y0;
                  w = 0;
                  case (mode)
                     0: w = (ls == 0 && xs == 0 && ys == 0) ? 1 : 0;
                     1: w = (ls == 0) ? (xs ? fu : 16 - fu) * (ys ? fv : 16 - fv) : 0;
                     2: w = (xs == 0 && ys == 0) ? (ls ? lf : 16 - lf) : 0;
                     default: w = (xs ? fu : 16 - fu) * (ys ? fv : 16 - fv) * (ls ? lf : 16 - lf);
                  endcase
                  sum += w * chan(tex_word(lv, x, y), fmt, ch);
               end
         if (sh > 0) sum = (sum + (1 << (sh - 1))) >> sh;
         res[31-8*ch -: 8] = 8'(sum);
      end
      return res;
   endfunction

   logic [31:0] q_exp [$];
   int          q_cyc [$];
   int          q_n   [$];
   string       q_tag [$];

   task automatic send(int u, int v, int lod, int mode, int fmt, string tag);
      req_u = CW'(u); req_v = CW'(v); req_lod = LODW'(lod);
      req_mode = 2'(mode); req_fmt = 2'(fmt); req_valid = 1'b1;
      if (!req_ready) stalls++;
      while (!req_ready) @(negedge clk);
      q_exp.push_back(expect_px(u, v, lod, mode, fmt));
      q_cyc.push_back(cyc);
      q_n.push_back(nreads(mode));
      q_tag.push_back(tag);
      @(posedge clk);
      @(negedge clk);
   endtask

   // output monitor: order, value, latency (R10)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_exp.size() == 0) begin
            check(0, "R10", "result with nothing outstanding", 1, 0);
         end else begin
            logic [31:0] e;
            int ac, n;
            string t;
            e = q_exp.pop_front(); ac = q_cyc.pop_front();
            n = q_n.pop_front(); t = q_tag.pop_front();
            check(out_color == e, t, "colour", out_color, e);
            check(cyc == ac + 1 + LAT + n, "R10", "latency", cyc - ac - 1, LAT + n);
         end
      end
   end

   function automatic string sweep_tag(int u, int v, int lod, int mode);
      if ((lod >> F) >= MAXL) return "R5";
      if (u >= 112 || v >= 112) return "R6";
      case (mode) 0: return "R1"; 1: return "R2"; 2: return "R3"; default: return "R4"; endcase
   endfunction

   initial begin
      int lods [10] = '{0, 7, 23, 40, 47, 48, 55, 63, 100, 127};
      int low;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(out_valid == 0, "R11", "out_valid in reset", out_valid, 0);
      check(mem_rd == 0, "R11", "mem_rd in reset", mem_rd, 0);
      check(req_ready == 1, "R11", "req_ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0 && mem_rd == 0, "R11", "idle after reset", {out_valid, mem_rd}, 0);

      // R1-R6 sweep over modes, levels and coordinates, 32-bit texels
      for (int m = 0; m < 4; m++)
         for (int li = 0; li < 10; li++) begin
            for (int u = 0; u < 128; u += 13)
               for (int v = 0; v < 128; v += 19)
                  send(u, v, lods[li], m, 0, sweep_tag(u, v, lods[li], m));
            send(127, 127, lods[li], m, 0, sweep_tag(127, 127, lods[li], m));
         end

      // R8 formats
      for (int fm = 1; fm < 4; fm++)
         for (int m = 0; m < 4; m++)
            for (int k = 0; k < 3; k++) begin
               send(k == 0 ? 5 : k == 1 ? 60 : 127, k == 0 ? 9 : k == 1 ? 77 : 120, 0, m, fm, "R8");
               send(k == 0 ? 33 : k == 1 ? 90 : 18, k == 0 ? 101 : k == 1 ? 4 : 66, 20, m, fm, "R8");
            end

      // R9 point-mode burst, then busy window of a trilinear request
      req_valid = 1'b0;
      repeat (12) @(negedge clk);
      stalls = 0;
      for (int i = 0; i < 16; i++) send(i * 8, 127 - i * 7, i * 3, 0, 0, "R1");
      check(stalls == 0, "R9", "stalls in point burst", stalls, 0);
      send(50, 70, 9, 3, 0, "R4");
      req_valid = 1'b0;
      low = 0;
      while (!req_ready && low < 20) begin low++; @(negedge clk); end
      check(low == 7, "R9", "ready-low cycles after 8-read request", low, 7);

      for (int i = 0; i < 200 && q_exp.size() != 0; i++) @(negedge clk);
      check(q_exp.size() == 0, "R10", "results outstanding at end", q_exp.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule